// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside an instruction execution unit. At each instruction boundary it decides whether the processor has to enter an interrupt handler, and if it does, it carries out the entry. The execution unit presents the current flags word, code segment, return instruction pointer and stack pointer. It also presents the pending request lines: a software interrupt with its type number, an overflow-conditional interrupt instruction, a non-maskable request, a maskable request with its type number, and the single-step trap taken from the flags word.

When an interrupt is taken, the sequencer writes three words below the stack pointer through a simple request/acknowledge memory port. It then reads the handler address from the vector table at four times the interrupt type. Finally it hands back the new code segment, instruction pointer, flags word and stack pointer, qualified by a single-cycle valid strobe.

When the overflow-conditional instruction finds the overflow flag clear, nothing is pushed. The sequencer stays busy for a fixed number of clocks and then returns the unchanged state.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, `busy`, `fetch_valid` and `mem_req` are all low.
- R2: When several sources are present on one accepted boundary, the order of precedence is: software interrupt (type `sw_type`), then overflow-conditional instruction, then non-maskable request (type 2), then unmasked maskable request (type `intr_type`), then single-step (type 1). Only the winner is served.
- R3: The single-step trap is raised as type 1 when flags bit 8 is 1 and no other source wins. On every interrupt entry, the returned flags word equals the pushed flags word with bit 8 and bit 9 cleared.
- R4: A maskable request is taken only when flags bit 9 is 1. When bit 9 is 0, a maskable request alone causes no `busy`, no `mem_req` and no `fetch_valid`. The non-maskable and software interrupts are taken regardless of bit 9.
- R5: When `ovf_req` is accepted with flags bit 11 set, type 4 is entered, with its vector at byte address 0x00010. With bit 11 clear, no memory request is made and `busy` is high for exactly `NOP_CYC` (default 4) cycles. `fetch_valid` then follows, with the code segment, instruction pointer, flags word and stack pointer all unchanged.
- R6: Entry writes the original flags word at byte address SP−2, then the code segment at SP−4, then the return instruction pointer at SP−6, in that order. Each address is the 16-bit value zero-extended to 20 bits. The returned stack pointer is SP−6.
- R7: After the pushes, the new instruction pointer is read from byte address type×4 and the new code segment from type×4+2.
- R8: `busy` is high from the cycle after acceptance up to the cycle before `fetch_valid`. `fetch_valid` is a single-cycle pulse during which `busy` is low.
- R9: Every memory transfer holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`. One word moves per acknowledge, so each entry makes exactly three writes and two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction-boundary strobe, accepted only while idle |
| flags_in | input | 16 | Current flags word (bit 8 step, bit 9 mask enable, bit 11 overflow) |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| sw_req | input | 1 | Software interrupt instruction at this boundary |
| sw_type | input | 8 | Software interrupt type |
| ovf_req | input | 1 | Overflow-conditional interrupt instruction at this boundary |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable request |
| intr_type | input | 8 | Type supplied with the maskable request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes this cycle |
| busy | output | 1 | Entry or no-op in progress |
| fetch_valid | output | 1 | New fetch state valid, one cycle |
| new_cs | output | 16 | Code segment to fetch from |
| new_ip | output | 16 | Instruction pointer to fetch from |
| new_flags | output | 16 | Flags word after entry |
| new_sp | output | 16 | Stack pointer after entry |

## Verification
A wrong arbitration or masking decision shows up within two cycles of the boundary: `mem_req` rises or stays low against expectation, or the vector read goes to a type×4 address other than the expected one. A bad word index or stack offset shows up in the stack image the memory model collects, after the third write. A lost or extra acknowledge count shows up in the transfer totals once `fetch_valid` arrives. A miscounted no-op timer shows up as a `busy` run of the wrong length, and is visible exactly at the strobe.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;
  localparam int TYPE_W = 8;
  localparam int STEP_BIT = 8;
  localparam int MASK_BIT = 9;
  localparam int OVF_BIT  = 11;
  localparam logic [TYPE_W-1:0] T_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] T_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] T_OVF  = 8'd4;

  typedef enum logic [2:0] {ST_IDLE, ST_PUSH, ST_VEC, ST_NOP, ST_DONE} seq_st_e;

  // byte address of vector half: type*4 (+2 for the segment half)
  function automatic logic [ADDR_W-1:0] vec_addr(logic [TYPE_W-1:0] t, logic hi);
    return {{(ADDR_W-TYPE_W-2){1'b0}}, t, hi, 1'b0};
  endfunction

  // stack slot for push number idx (0: flags, 1: cs, 2: ip)
  function automatic logic [WORD_W-1:0] push_slot(logic [WORD_W-1:0] sp, logic [1:0] idx);
    return sp - ({{(WORD_W-3){1'b0}}, idx, 1'b0} + WORD_W'(2));
  endfunction
endpackage

// File: rtl/intr_arb.sv
module intr_arb
  import intr_seq_pkg::*;
(
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              ovf_req,
  input  logic              of_bit,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              if_bit,
  input  logic              tf_bit,
  output logic              take_int,
  output logic              take_nop,
  output logic [TYPE_W-1:0] vtype
);
  always_comb begin
    take_int = 1'b1;
    take_nop = 1'b0;
    vtype    = '0;
    if (sw_req)                 vtype = sw_type;
    else if (ovf_req && of_bit) vtype = T_OVF;
    else if (ovf_req) begin
      take_int = 1'b0;
      take_nop = 1'b1;
    end
    else if (nmi_req)            vtype = T_NMI;
    else if (intr_req && if_bit) vtype = intr_type;
    else if (tf_bit)             vtype = T_STEP;
    else                         take_int = 1'b0;
  end

  always_comb begin
    AST_ONE_OUTCOME: assert (!(take_int && take_nop)); // R2
  end
endmodule

// File: rtl/intr_nop_timer.sv
module intr_nop_timer #(
  parameter int NOP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic run,
  output logic expire
);
  localparam int CW = $clog2(NOP_CYC + 1);
  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(NOP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (expire) run <= 1'b0;
      else        cnt <= cnt + 1'b1;
    end
  end

  AST_NOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < CW'(NOP_CYC)); // R5
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int NOP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              ovf_req,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              fetch_valid,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [WORD_W-1:0] new_flags,
  output logic [WORD_W-1:0] new_sp
);
  seq_st_e           st;
  logic [1:0]        idx;
  logic [WORD_W-1:0] fl_q, cs_q, ip_q, sp_q;
  logic [TYPE_W-1:0] type_q;
  logic              took_int;

  // named internal events
  logic              take_int, take_nop, accept, nop_run, nop_done;
  logic [TYPE_W-1:0] vtype;
  logic              last_push, last_read;

  intr_arb u_arb (
    .sw_req   (sw_req),
    .sw_type  (sw_type),
    .ovf_req  (ovf_req),
    .of_bit   (flags_in[OVF_BIT]),
    .nmi_req  (nmi_req),
    .intr_req (intr_req),
    .intr_type(intr_type),
    .if_bit   (flags_in[MASK_BIT]),
    .tf_bit   (flags_in[STEP_BIT]),
    .take_int (take_int),
    .take_nop (take_nop),
    .vtype    (vtype)
  );

  assign accept = (st == ST_IDLE) && boundary && (take_int || take_nop);

  intr_nop_timer #(.NOP_CYC(NOP_CYC)) u_nop (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept && take_nop),
    .run   (nop_run),
    .expire(nop_done)
  );

  assign last_push = (st == ST_PUSH) && mem_ack && (idx == 2'd2);
  assign last_read = (st == ST_VEC) && mem_ack && (idx == 2'd1);

  assign mem_req     = (st == ST_PUSH) || (st == ST_VEC);
  assign mem_we      = (st == ST_PUSH);
  assign busy        = (st == ST_PUSH) || (st == ST_VEC) || (st == ST_NOP);
  assign fetch_valid = (st == ST_DONE);

  always_comb begin
    if (st == ST_VEC) mem_addr = vec_addr(type_q, idx[0]);
    else              mem_addr = {{(ADDR_W-WORD_W){1'b0}}, push_slot(sp_q, idx)};
    case (idx)
      2'd0:    mem_wdata = fl_q;
      2'd1:    mem_wdata = cs_q;
      default: mem_wdata = ip_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      fl_q      <= '0;
      cs_q      <= '0;
      ip_q      <= '0;
      sp_q      <= '0;
      type_q    <= '0;
      took_int  <= 1'b0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_flags <= '0;
      new_sp    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          fl_q     <= flags_in;
          cs_q     <= cs_in;
          ip_q     <= ip_in;
          sp_q     <= sp_in;
          type_q   <= vtype;
          took_int <= take_int;
          idx      <= '0;
          st       <= take_int ? ST_PUSH : ST_NOP;
        end
        ST_PUSH: if (mem_ack) begin
          idx <= last_push ? 2'd0 : idx + 2'd1;
          if (last_push) st <= ST_VEC;
        end
        ST_VEC: if (mem_ack) begin
          idx <= idx + 2'd1;
          if (idx == 2'd0) new_ip <= mem_rdata;
          if (last_read) begin
            new_cs    <= mem_rdata;
            new_flags <= fl_q & ~(WORD_W'(1) << STEP_BIT) & ~(WORD_W'(1) << MASK_BIT);
            new_sp    <= push_slot(sp_q, 2'd2);
            st        <= ST_DONE;
          end
        end
        ST_NOP: if (nop_done) begin
          new_cs    <= cs_q;
          new_ip    <= ip_q;
          new_flags <= fl_q;
          new_sp    <= sp_q;
          st        <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && fetch_valid)); // R8
  AST_FV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !fetch_valid && !busy); // R8
  AST_STEP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && took_int |-> !new_flags[STEP_BIT] && !new_flags[MASK_BIT]); // R3
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nop_run |-> !mem_req); // R5
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && boundary && intr_req && !flags_in[MASK_BIT] && !sw_req && !ovf_req
      && !nmi_req && !flags_in[STEP_BIT] |=> !busy); // R4
endmodule

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
  localparam int CLK_PER = 10;
  localparam int NOP_CYC = 4;

  logic clk = 0, rst_n = 0;
  logic boundary = 0;
  logic [15:0] flags_in = 0, cs_in = 0, ip_in = 0, sp_in = 0;
  logic sw_req = 0, ovf_req = 0, nmi_req = 0, intr_req = 0;
  logic [7:0] sw_type = 0, intr_type = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic busy, fetch_valid;
  logic [15:0] new_cs, new_ip, new_flags, new_sp;

  logic [15:0] mem [0:1023];
  int mem_lat = 1, wcnt = 0, nwr = 0, nrd = 0, n_req = 0;
  int checks = 0, fails = 0;

  always #(CLK_PER/2) clk = ~clk;

  intr_entry_seq #(.NOP_CYC(NOP_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .flags_in(flags_in),
    .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .sw_req(sw_req), .sw_type(sw_type),
    .ovf_req(ovf_req), .nmi_req(nmi_req), .intr_req(intr_req), .intr_type(intr_type),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .fetch_valid(fetch_valid),
    .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags), .new_sp(new_sp));

  // memory model: acknowledges after mem_lat cycles of request
  always @(negedge clk) begin
    if (mem_req) n_req = n_req + 1;
    if (mem_ack) begin
      mem_ack <= 0;
      wcnt = 0;
    end else if (mem_req && rst_n) begin
      if (wcnt + 1 >= mem_lat) begin
        mem_ack <= 1;
        if (mem_we) begin mem[mem_addr[10:1]] = mem_wdata; nwr = nwr + 1; end
        else begin mem_rdata <= mem[mem_addr[10:1]]; nrd = nrd + 1; end
      end else wcnt = wcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vip(input logic [7:0] t); return 16'h1000 + 16'(t); endfunction
  function automatic logic [15:0] vcs(input logic [7:0] t); return 16'hC000 + 16'(t); endfunction

  task automatic clear_reqs();
    sw_req = 0; ovf_req = 0; nmi_req = 0; intr_req = 0;
  endtask

  // pulse boundary, then wait for the strobe; returns busy run length
  task automatic fire(output int busy_n, output bit seen, output bit busy_gap);
    int k;
    nwr = 0; nrd = 0; n_req = 0;
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    busy_n = 0; seen = 0; busy_gap = 0;
    for (k = 0; k < 200 && !seen; k++) begin
      if (fetch_valid) seen = 1;
      else begin
        if (busy) busy_n++; else busy_gap = 1;
        @(negedge clk);
      end
    end
  endtask

  task automatic expect_entry(input string tag, input logic [7:0] t);
    int bn; bit seen, gap;
    fire(bn, seen, gap);
    chk({tag, " R8 strobe"}, seen, 1);
    chk({tag, " R8 busy continuous"}, gap, 0);
    chk({tag, " R7 new_ip"}, new_ip, vip(t));
    chk({tag, " R7 new_cs"}, new_cs, vcs(t));
    chk({tag, " R3 new_flags"}, new_flags, flags_in & 16'hFCFF);
    chk({tag, " R6 new_sp"}, new_sp, sp_in - 16'd6);
    chk({tag, " R6 flags slot"}, mem[(sp_in - 16'd2) >> 1], flags_in);
    chk({tag, " R6 cs slot"}, mem[(sp_in - 16'd4) >> 1], cs_in);
    chk({tag, " R6 ip slot"}, mem[(sp_in - 16'd6) >> 1], ip_in);
    chk({tag, " R9 writes"}, nwr, 3);
    chk({tag, " R9 reads"}, nrd, 2);
    @(negedge clk);
    chk({tag, " R8 single pulse"}, fetch_valid, 0);
  endtask

  task automatic set_ctx(input logic [15:0] f, input logic [15:0] ip);
    flags_in = f; cs_in = 16'h3A5C; ip_in = ip; sp_in = 16'h0700;
    for (int i = 0; i < 3; i++) mem[(16'h0700 - 16'(2*(i+1))) >> 1] = 16'hDEAD;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 fetch_valid", fetch_valid, 0);
    chk("R1 mem_req", mem_req, 0);
  endtask

  task automatic t_sw_over_step();
    clear_reqs(); mem_lat = 1;
    set_ctx(16'h0302, 16'h0111);
    sw_req = 1; sw_type = 8'h21;
    expect_entry("sw R2", 8'h21);
  endtask

  task automatic t_ovf_taken();
    clear_reqs(); mem_lat = 3;
    set_ctx(16'h0A00, 16'h0222);
    ovf_req = 1; nmi_req = 1;
    expect_entry("ovf R5", 8'd4);
  endtask

  task automatic t_ovf_nop();
    int bn; bit seen, gap;
    clear_reqs(); mem_lat = 1;
    set_ctx(16'h0200, 16'h0333);
    ovf_req = 1;
    fire(bn, seen, gap);
    chk("R5 nop strobe", seen, 1);
    chk("R5 nop busy length", bn, NOP_CYC);
    chk("R5 nop no memory", n_req, 0);
    chk("R5 nop ip", new_ip, 16'h0333);
    chk("R5 nop cs", new_cs, 16'h3A5C);
    chk("R5 nop flags", new_flags, 16'h0200);
    chk("R5 nop sp", new_sp, 16'h0700);
    @(negedge clk);
  endtask

  task automatic t_masked();
    int seen_busy = 0, seen_fv = 0;
    clear_reqs();
    set_ctx(16'h0000, 16'h0444);
    intr_req = 1; intr_type = 8'h40;
    n_req = 0;
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    for (int k = 0; k < 10; k++) begin
      if (busy) seen_busy++;
      if (fetch_valid) seen_fv++;
      @(negedge clk);
    end
    chk("R4 masked busy", seen_busy, 0);
    chk("R4 masked strobe", seen_fv, 0);
    chk("R4 masked mem", n_req, 0);
  endtask

  task automatic t_nmi_if0();
    clear_reqs(); mem_lat = 2;
    set_ctx(16'h0001, 16'h0555);
    nmi_req = 1; intr_req = 1;
    expect_entry("nmi R4", 8'd2);
  endtask

  task automatic t_intr_taken();
    clear_reqs(); mem_lat = 1;
    set_ctx(16'h0300, 16'h0666);
    intr_req = 1; intr_type = 8'h40;
    expect_entry("intr R4 R2", 8'h40);
  endtask

  task automatic t_step();
    clear_reqs(); mem_lat = 2;
    set_ctx(16'h0100, 16'h0777);
    intr_req = 1; intr_type = 8'h55;
    expect_entry("step R3", 8'd1);
  endtask

  task automatic t_sw_if0();
    clear_reqs(); mem_lat = 1;
    set_ctx(16'h0800, 16'h0888);
    sw_req = 1; sw_type = 8'hFF; ovf_req = 1; nmi_req = 1;
    expect_entry("sw max R2 R4", 8'hFF);
  endtask

  initial begin
    #(CLK_PER * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 256; t++) begin
      mem[t*2]     = 16'h1000 + 16'(t);
      mem[t*2 + 1] = 16'hC000 + 16'(t);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sw_over_step();
    t_ovf_taken();
    t_ovf_nop();
    t_masked();
    t_nmi_if0();
    t_intr_taken();
    t_step();
    t_sw_if0();
    clear_reqs();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule